// File: doc/BRIEF.md
# Interleaved Dual-Bank Video Memory Burst Translator

This block turns a linear byte burst (start address, byte count, direction) into a series of word accesses to a video store built from two 32-bit banks that interleave on 4-byte boundaries. The word at linear address A lives in bank A[2], at in-bank word index A[22:3]. A linear stream therefore alternates between the banks. The in-bank index steps forward only when the access moves from bank 1 back to bank 0.

A host gives a request with a valid/ready handshake. For a write it then streams bytes in through `wr_valid`/`wr_ready`. For a read it takes bytes out through `rd_valid`/`rd_ready`. Bytes are staged in a 4-lane word buffer. Each touched word costs exactly one memory access, and the byte enables cover only the lanes the burst touches. This covers a partial first word, full middle words and a partial last word. The address window is 8 MB. A burst that would run past its end is shortened. A one-cycle `done` pulse closes every request, including an empty one.

Top module: `vram_il_burst`

## Requirements
- R1: Only bits 22:0 of `req_addr` select the start address, so addresses that differ only above bit 22 address the same bytes.
- R2: When masked start plus `req_len` exceeds 0x800000, exactly 0x800000 minus the masked start bytes are transferred. No further write byte is accepted (`wr_ready` stays low) and no further read byte is produced.
- R3: The byte at linear address A is stored in bank A[2], word index A[22:3], lane A[1:0]. Lane i occupies data bits 8i+7:8i and `mem_be` bit i, so lane 0 holds the lowest address.
- R4: Successive word accesses of one burst alternate banks. The word index rises by one on a bank 1 to bank 0 step and stays the same on a bank 0 to bank 1 step.
- R5: A start address with A[1:0] = k accesses its first word with enables on lanes k up to 3, or fewer lanes if the burst ends inside that word.
- R6: Every word fully covered by the burst is accessed once with `mem_be` = 4'b1111.
- R7: A last word that is only partly covered is accessed with enables on lanes 0 to n-1, where n is the 1 to 3 remaining bytes.
- R8: A read issues the same bank, index and enable sequence as a write of the same burst, with `mem_we` low. It expects `mem_rdata` one cycle after each access and delivers bytes in ascending address order.
- R9: `done` is high for one cycle. For a write it comes two cycles after the last byte is accepted. For a read it comes one cycle after the last byte handshake.
- R10: `req_ready` is high only while no request is in progress. It is high after reset and low from the cycle after acceptance until `done` has passed.
- R11: A request whose effective length is zero makes no memory access and raises `done` in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 32 | Start byte address; bits above 22 ignored |
| req_len | input | 24 | Byte count |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken |
| wr_byte | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte taken |
| rd_byte | output | 8 | Read byte |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_bank | output | 1 | Bank select |
| mem_widx | output | 20 | Word index inside the bank |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data, lane i in bits 8i+7:8i |
| mem_rdata | input | 32 | Read data, valid one cycle after a read access |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
Each word access appears in the cycle after the last byte of that word is accepted (writes) or right after the previous word drains (reads). It is compared against a queue that the driver fills from the address arithmetic alone. For reads the returned byte is due two cycles after the access. For writes `done` is due two cycles after the last accepted byte; for reads it is due one cycle after the last byte handshake; for an empty request it is due one cycle after acceptance. The bench samples every output at the falling edge and stamps each handshake and each `done` with a falling-edge count, so it checks these distances exactly rather than with a loose wait.

// File: rtl/vram_il_pkg.sv
package vram_il_pkg;

    localparam int unsigned LANES      = 4;
    localparam int unsigned LANE_BITS  = 8;
    localparam int unsigned WORD_BITS  = LANES * LANE_BITS;
    localparam int unsigned LANE_IDX_W = $clog2(LANES);
    localparam int unsigned LANE_CNT_W = LANE_IDX_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GATHER,
        ST_WR_ISSUE,
        ST_RD_ISSUE,
        ST_RD_CAPTURE,
        ST_EMIT,
        ST_DONE
    } xfer_state_e;

    // One word-sized piece of a burst
    typedef struct packed {
        logic                  bank;
        logic [LANE_IDX_W-1:0] off;
        logic [LANE_CNT_W-1:0] cnt;
        logic                  last;
    } seg_info_t;

    function automatic logic [LANES-1:0] lane_mask(
        input logic [LANE_IDX_W-1:0] off,
        input logic [LANE_CNT_W-1:0] cnt
    );
        logic [LANES-1:0] m;
        int lo;
        int hi;
        lo = int'(off);
        hi = lo + int'(cnt);
        for (int i = 0; i < int'(LANES); i++) begin
            m[i] = (i >= lo) && (i < hi);
        end
        return m;
    endfunction

endpackage

// File: rtl/vram_il_clip.sv
module vram_il_clip #(
    parameter int HOST_ADDR_W = 32,
    parameter int ADDR_W      = 23,
    parameter int LEN_W       = 24
) (
    input  logic [HOST_ADDR_W-1:0] raw_addr,
    input  logic [LEN_W-1:0]       raw_len,
    output logic [ADDR_W-1:0]      base,
    output logic [LEN_W-1:0]       len_eff
);
    localparam int SUM_W = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;

    logic [SUM_W-1:0] end_sum;
    logic [SUM_W-1:0] limit;
    logic [SUM_W-1:0] room;

    assign base    = raw_addr[ADDR_W-1:0];
    assign end_sum = SUM_W'(base) + SUM_W'(raw_len);
    assign limit   = SUM_W'(1) << ADDR_W;
    assign room    = limit - SUM_W'(base);
    assign len_eff = (end_sum > limit) ? LEN_W'(room) : raw_len;

    if (HOST_ADDR_W > ADDR_W) begin : g_hi
        logic unused_hi;
        assign unused_hi = ^raw_addr[HOST_ADDR_W-1:ADDR_W];
    end

endmodule

// File: rtl/vram_il_seg.sv
module vram_il_seg
    import vram_il_pkg::*;
#(
    parameter int ADDR_W = 23,
    parameter int LEN_W  = 24
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [LEN_W-1:0]  rem,
    output seg_info_t         seg,
    output logic [ADDR_W-4:0] widx
);
    logic [LANE_CNT_W-1:0] room;
    logic                  short_tail;

    assign room       = LANE_CNT_W'(LANES) - {1'b0, cur[LANE_IDX_W-1:0]};
    assign short_tail = rem < LEN_W'(room);

    assign seg.off  = cur[LANE_IDX_W-1:0];
    assign seg.bank = cur[2];
    assign seg.cnt  = short_tail ? rem[LANE_CNT_W-1:0] : room;
    assign seg.last = (rem == LEN_W'(seg.cnt));
    assign widx     = cur[ADDR_W-1:3];

endmodule

// File: rtl/vram_il_lanes.sv
module vram_il_lanes
    import vram_il_pkg::*;
#(
    parameter int NLANES = LANES,
    parameter int BYTE_W = LANE_BITS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       put_en,
    input  logic [$clog2(NLANES)-1:0]  put_lane,
    input  logic [BYTE_W-1:0]          put_byte,
    input  logic                       load_en,
    input  logic [NLANES*BYTE_W-1:0]   load_word,
    input  logic [$clog2(NLANES)-1:0]  get_lane,
    output logic [NLANES*BYTE_W-1:0]   word,
    output logic [BYTE_W-1:0]          get_byte
);
    localparam int SEL_W = $clog2(NLANES);

    logic [BYTE_W-1:0] lane_q [NLANES];

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                lane_q[g] <= '0;
            end else if (load_en) begin
                lane_q[g] <= load_word[g*BYTE_W +: BYTE_W];
            end else if (put_en && (put_lane == SEL_W'(g))) begin
                lane_q[g] <= put_byte;
            end
        end
        assign word[g*BYTE_W +: BYTE_W] = lane_q[g];
    end

    assign get_byte = lane_q[get_lane];

endmodule

// File: rtl/vram_il_burst.sv
module vram_il_burst
    import vram_il_pkg::*;
#(
    parameter int HOST_ADDR_W = 32,
    parameter int ADDR_W      = 23,
    parameter int LEN_W       = 24
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [HOST_ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]       req_len,
    input  logic                   req_write,
    input  logic                   wr_valid,
    output logic                   wr_ready,
    input  logic [LANE_BITS-1:0]   wr_byte,
    output logic                   rd_valid,
    input  logic                   rd_ready,
    output logic [LANE_BITS-1:0]   rd_byte,
    output logic                   mem_en,
    output logic                   mem_we,
    output logic                   mem_bank,
    output logic [ADDR_W-4:0]      mem_widx,
    output logic [LANES-1:0]       mem_be,
    output logic [WORD_BITS-1:0]   mem_wdata,
    input  logic [WORD_BITS-1:0]   mem_rdata,
    output logic                   done
);
    localparam int WIDX_W = ADDR_W - 3;

    xfer_state_e           state_q, state_d;
    logic [ADDR_W-1:0]     cur_q;
    logic [LEN_W-1:0]      rem_q;
    logic [LANE_IDX_W-1:0] k_q;

    logic [ADDR_W-1:0]     base;
    logic [LEN_W-1:0]      len_eff;
    seg_info_t             seg;
    logic [WIDX_W-1:0]     seg_widx;

    logic                  accept;
    logic                  seg_end_byte;
    logic                  byte_step;
    logic                  advance;
    logic [LANE_IDX_W-1:0] lane_sel;
    logic [WORD_BITS-1:0]  stage_word;
    logic [LANE_BITS-1:0]  stage_byte;

    vram_il_clip #(
        .HOST_ADDR_W(HOST_ADDR_W),
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W)
    ) clip_i (
        .raw_addr(req_addr),
        .raw_len (req_len),
        .base    (base),
        .len_eff (len_eff)
    );

    vram_il_seg #(
        .ADDR_W(ADDR_W),
        .LEN_W (LEN_W)
    ) seg_i (
        .cur (cur_q),
        .rem (rem_q),
        .seg (seg),
        .widx(seg_widx)
    );

    vram_il_lanes #(
        .NLANES(LANES),
        .BYTE_W(LANE_BITS)
    ) lanes_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (accept || (state_q == ST_WR_ISSUE)),
        .put_en   (wr_valid && wr_ready),
        .put_lane (lane_sel),
        .put_byte (wr_byte),
        .load_en  (state_q == ST_RD_CAPTURE),
        .load_word(mem_rdata),
        .get_lane (lane_sel),
        .word     (stage_word),
        .get_byte (stage_byte)
    );

    assign req_ready    = (state_q == ST_IDLE);
    assign accept       = req_valid && req_ready;
    assign lane_sel     = seg.off + k_q;
    assign seg_end_byte = (({1'b0, k_q} + LANE_CNT_W'(1)) == seg.cnt);

    assign wr_ready  = (state_q == ST_GATHER);
    assign rd_valid  = (state_q == ST_EMIT);
    assign rd_byte   = stage_byte;
    assign mem_en    = (state_q == ST_WR_ISSUE) || (state_q == ST_RD_ISSUE);
    assign mem_we    = (state_q == ST_WR_ISSUE);
    assign mem_bank  = seg.bank;
    assign mem_widx  = seg_widx;
    assign mem_be    = lane_mask(seg.off, seg.cnt);
    assign mem_wdata = stage_word;
    assign done      = (state_q == ST_DONE);

    assign byte_step = ((state_q == ST_GATHER) && wr_valid) ||
                       ((state_q == ST_EMIT) && rd_ready);
    assign advance   = (state_q == ST_WR_ISSUE) ||
                       ((state_q == ST_EMIT) && rd_ready && seg_end_byte);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (len_eff == '0)  state_d = ST_DONE;
                    else if (req_write) state_d = ST_GATHER;
                    else                state_d = ST_RD_ISSUE;
                end
            end
            ST_GATHER:     if (wr_valid && seg_end_byte) state_d = ST_WR_ISSUE;
            ST_WR_ISSUE:   state_d = seg.last ? ST_DONE : ST_GATHER;
            ST_RD_ISSUE:   state_d = ST_RD_CAPTURE;
            ST_RD_CAPTURE: state_d = ST_EMIT;
            ST_EMIT: begin
                if (rd_ready && seg_end_byte) state_d = seg.last ? ST_DONE : ST_RD_ISSUE;
            end
            ST_DONE:       state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            rem_q   <= '0;
            k_q     <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cur_q <= base;
                rem_q <= len_eff;
                k_q   <= '0;
            end else begin
                if (byte_step) k_q <= seg_end_byte ? '0 : k_q + LANE_IDX_W'(1);
                if (advance) begin
                    cur_q <= cur_q + ADDR_W'(seg.cnt);
                    rem_q <= rem_q - LEN_W'(seg.cnt);
                end
            end
        end
    end

    // Previous access of the current burst, kept for the checks below
    logic              seen_q;
    logic              prev_bank_q;
    logic [WIDX_W-1:0] prev_widx_q;

    always_ff @(posedge clk) begin
        if (rst || accept) begin
            seen_q      <= 1'b0;
            prev_bank_q <= 1'b0;
            prev_widx_q <= '0;
        end else if (mem_en) begin
            seen_q      <= 1'b1;
            prev_bank_q <= mem_bank;
            prev_widx_q <= mem_widx;
        end
    end

    a_r4_bank_alternates: assert property (@(posedge clk) disable iff (rst)
        (mem_en && seen_q) |-> (mem_bank != prev_bank_q));

    a_r4_index_step: assert property (@(posedge clk) disable iff (rst)
        (mem_en && seen_q) |->
            (mem_widx == (mem_bank ? prev_widx_q : prev_widx_q + WIDX_W'(1))));

    a_r7_later_from_lane0: assert property (@(posedge clk) disable iff (rst)
        (mem_en && seen_q) |-> mem_be[0]);

    a_r5_be_nonzero: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> (mem_be != '0));

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);

    a_r11_empty_request: assert property (@(posedge clk) disable iff (rst)
        (accept && (len_eff == '0)) |=> (done && !mem_en));

endmodule

// File: tb/vram_il_burst_tb.sv
module vram_il_burst_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [23:0] req_len = '0;
    logic        req_write = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [7:0]  wr_byte = '0;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic [7:0]  rd_byte;
    logic        mem_en;
    logic        mem_we;
    logic        mem_bank;
    logic [19:0] mem_widx;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        done;

    always #2 clk = ~clk;   // 4 ns period, 250 MHz

    vram_il_burst dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_write(req_write),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_byte(wr_byte),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_byte(rd_byte),
        .mem_en(mem_en), .mem_we(mem_we), .mem_bank(mem_bank),
        .mem_widx(mem_widx), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .done(done)
    );

    typedef struct {
        bit          we;
        bit          bank;
        int          widx;
        logic [3:0]  be;
        logic [31:0] data;
    } acc_t;

    acc_t        exp_q[$];
    logic [7:0]  rd_q[$];
    logic [7:0]  wq[$];
    logic [7:0]  ref_mem[int];
    logic [31:0] store[int];

    int    n_checks = 0;
    int    n_fail = 0;
    int    ncyc = 0;
    int    hs_ncyc = -1;
    int    done_ncyc = -1;
    int    acc_bytes = 0;
    string cur_tag = "reset";
    bit    finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s [%s]: actual %0h expected %0h", req, what, cur_tag, act, expv);
        end
    endtask

    function automatic logic [31:0] mask32(input logic [3:0] be);
        logic [31:0] m;
        for (int l = 0; l < 4; l++) m[l*8 +: 8] = be[l] ? 8'hFF : 8'h00;
        return m;
    endfunction

    // Single-port store split into two banks, registered read
    always @(posedge clk) begin
        if (mem_en) begin
            automatic int key = int'({mem_bank, mem_widx});
            automatic logic [31:0] w = store.exists(key) ? store[key] : 32'h0;
            if (mem_we) begin
                for (int l = 0; l < 4; l++) if (mem_be[l]) w[l*8 +: 8] = mem_wdata[l*8 +: 8];
                store[key] = w;
            end else begin
                mem_rdata <= w;
            end
        end
    end

    // Monitor: pops expected accesses and read bytes, stamps handshakes
    always @(negedge clk) begin
        ncyc++;
        if (!rst) begin
            if (mem_en) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2/R11", "unexpected memory access", {mem_bank, mem_widx}, 0);
                end else begin
                    automatic acc_t e = exp_q.pop_front();
                    check(mem_we == e.we, "R8", "write strobe", mem_we, e.we);
                    check(mem_bank == e.bank, "R3/R4", "bank", mem_bank, e.bank);
                    check(int'(mem_widx) == e.widx, "R3/R4", "word index", mem_widx, e.widx);
                    check(mem_be == e.be, "R5/R6/R7", "byte enables", mem_be, e.be);
                    if (e.we)
                        check((mem_wdata & mask32(e.be)) == e.data, "R3", "write data",
                              mem_wdata & mask32(e.be), e.data);
                end
            end
            if (wr_valid && wr_ready) begin
                hs_ncyc = ncyc;
                acc_bytes++;
            end
            if (rd_valid && rd_ready) begin
                hs_ncyc = ncyc;
                acc_bytes++;
                if (rd_q.size() == 0) begin
                    check(1'b0, "R2", "read byte beyond burst", rd_byte, 0);
                end else begin
                    automatic logic [7:0] b = rd_q.pop_front();
                    check(rd_byte == b, "R8", "read byte", rd_byte, b);
                end
            end
            if (done) done_ncyc = ncyc;
        end
    end

    // Expected accesses derived from the address mapping, byte by byte
    function automatic longint plan(input logic [31:0] addr, input longint len,
                                    input bit we, input int seed);
        longint m;
        longint n;
        longint cw;
        acc_t   e;
        m  = longint'(addr & 32'h007F_FFFF);
        n  = len;
        cw = -1;
        e  = '{we: 1'b0, bank: 1'b0, widx: 0, be: 4'h0, data: 32'h0};
        if (m + n > 64'h80_0000) n = 64'h80_0000 - m;
        for (longint i = 0; i < n; i++) begin
            automatic longint a = m + i;
            automatic int l = int'(a[1:0]);
            automatic logic [7:0] b = 8'h00;
            if ((a >> 2) != cw) begin
                if (cw >= 0) exp_q.push_back(e);
                cw     = a >> 2;
                e.we   = we;
                e.bank = a[2];
                e.widx = int'(a[22:3]);
                e.be   = 4'h0;
                e.data = 32'h0;
            end
            if (we) begin
                b = 8'((seed + int'(i) * 7) & 255);
                ref_mem[int'(a)] = b;
                wq.push_back(b);
            end else begin
                rd_q.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00);
            end
            e.be[l] = 1'b1;
            e.data[l*8 +: 8] = b;
        end
        if (cw >= 0) exp_q.push_back(e);
        return n;
    endfunction

    task automatic send_req(input logic [31:0] addr, input logic [23:0] len,
                            input bit we, output int acc_nc);
        @(posedge clk); #1;
        req_valid = 1'b1;
        req_addr  = addr;
        req_len   = len;
        req_write = we;
        forever begin
            @(negedge clk); #1;
            if (req_ready) break;
        end
        acc_nc = ncyc;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic do_write(input string tag, input logic [31:0] addr,
                            input logic [23:0] len, input int seed, input bit stall);
        longint n;
        int acc_nc;
        int ready_seen;
        ready_seen = 0;
        cur_tag = tag;
        wq.delete();
        n = plan(addr, longint'(len), 1'b1, seed);
        acc_bytes = 0; hs_ncyc = -1; done_ncyc = -1;
        send_req(addr, len, 1'b1, acc_nc);
        @(negedge clk); #1;
        check(!req_ready, "R10", "ready while busy", req_ready, 0);
        for (int i = 0; i < int'(n); i++) begin
            @(posedge clk); #1;
            if (stall && (i % 3 == 1)) begin
                wr_valid = 1'b0;
                @(posedge clk); #1;
            end
            wr_valid = 1'b1;
            wr_byte  = wq[i];
            forever begin
                @(negedge clk); #1;
                if (wr_ready) break;
            end
        end
        @(posedge clk); #1;
        wr_valid = 1'b1;        // surplus byte, must not be taken (R2)
        wr_byte  = 8'hEE;
        for (int t = 0; t < 50; t++) begin
            if (done_ncyc >= 0) break;
            @(negedge clk); #1;
            if (wr_ready) ready_seen++;
        end
        wr_valid = 1'b0;
        check(done_ncyc >= 0, "R9", "done seen", done_ncyc, 1);
        check(acc_bytes == int'(n), "R2", "bytes accepted", acc_bytes, n);
        check(ready_seen == 0, "R2", "ready after last byte", ready_seen, 0);
        if (n > 0) check(done_ncyc - hs_ncyc == 2, "R9", "write done latency", done_ncyc - hs_ncyc, 2);
        else       check(done_ncyc - acc_nc == 1, "R11", "empty done latency", done_ncyc - acc_nc, 1);
        check(exp_q.size() == 0, "R3", "accesses left undone", exp_q.size(), 0);
        @(posedge clk); #1;
    endtask

    task automatic do_read(input string tag, input logic [31:0] addr,
                           input logic [23:0] len, input bit stall);
        longint n;
        int acc_nc;
        cur_tag = tag;
        rd_q.delete();
        n = plan(addr, longint'(len), 1'b0, 0);
        acc_bytes = 0; hs_ncyc = -1; done_ncyc = -1;
        send_req(addr, len, 1'b0, acc_nc);
        @(negedge clk); #1;
        check(!req_ready, "R10", "ready while busy", req_ready, 0);
        for (int t = 0; t < 400; t++) begin
            if (done_ncyc >= 0) break;
            @(posedge clk); #1;
            rd_ready = stall ? (t % 2 == 1) : 1'b1;
            @(negedge clk); #1;
        end
        rd_ready = 1'b0;
        check(done_ncyc >= 0, "R9", "done seen", done_ncyc, 1);
        check(acc_bytes == int'(n), "R2", "bytes delivered", acc_bytes, n);
        check(rd_q.size() == 0, "R8", "bytes missing", rd_q.size(), 0);
        if (n > 0) check(done_ncyc - hs_ncyc == 1, "R9", "read done latency", done_ncyc - hs_ncyc, 1);
        else       check(done_ncyc - acc_nc == 1, "R11", "empty done latency", done_ncyc - acc_nc, 1);
        check(exp_q.size() == 0, "R8", "accesses left undone", exp_q.size(), 0);
        @(posedge clk); #1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired [%s]: actual hung expected finished", cur_tag);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        check(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);
        check(done == 1'b0, "R9", "done after reset", done, 0);
        check(mem_en == 1'b0, "R11", "access after reset", mem_en, 0);
        check(wr_ready == 1'b0 && rd_valid == 1'b0, "R10", "stream idle after reset",
              {wr_ready, rd_valid}, 0);

        do_write("R6 aligned write", 32'h0000_0100, 24'd16, 16, 1'b0);
        do_read ("R8 aligned read", 32'h0000_0100, 24'd16, 1'b1);
        do_write("R5 R7 unaligned write", 32'h0000_0203, 24'd11, 64, 1'b1);
        do_write("R5 inside one word", 32'h0000_0301, 24'd2, 200, 1'b0);
        do_read ("R8 unaligned read", 32'h0000_0202, 24'd13, 1'b0);
        do_read ("R5 read inside one word", 32'h0000_0300, 24'd4, 1'b1);
        do_write("R2 clipped write", 32'hFF7F_FFFA, 24'd20, 90, 1'b0);
        do_read ("R2 clipped read", 32'h127F_FFF0, 24'hFF_FFFF, 1'b1);
        do_write("R11 empty write", 32'h0000_0040, 24'd0, 5, 1'b0);
        do_read ("R11 empty read", 32'h0000_0040, 24'd0, 1'b0);
        do_write("R2 last byte", 32'h007F_FFFF, 24'd1, 33, 1'b0);
        do_read ("R2 top of window", 32'h00FF_FFFE, 24'd5, 1'b0);
        do_write("R1 alias write", 32'h0080_0040, 24'd8, 120, 1'b1);
        do_read ("R1 alias read", 32'h0000_0040, 24'd8, 1'b0);

        repeat (4) @(posedge clk);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule